// File: doc/BRIEF.md
# Pipelined Sum of Absolute Differences

This block is the arithmetic core of a block-matching motion search. On each issue it takes eight reference pixels and eight candidate pixels and returns the sum of their per-pixel absolute differences. The pixels are unsigned 8-bit values packed four to a 32-bit word, so one issue carries four operand words: two for the reference row and two for the candidate row. This matches what a register-file read port supplies to an execution unit.

The datapath has three register stages. The first stage forms all eight absolute differences in parallel. The second stage adds each word pair's four differences into its own partial sum. The third stage adds the two partial sums and zero-extends the total to a 32-bit writeback word. A valid flag travels alongside the data. A new operand set can be issued every cycle and there is no backpressure. Search control, address generation and motion-vector choice belong to the surrounding logic.

Top module: `sad_pipe`

## Requirements
- R1: Pixel i of a word occupies bits [8i+7:8i], with i = 0 to 3. Byte i of `ref_lo` pairs only with byte i of `cand_lo`, and byte i of `ref_hi` pairs only with byte i of `cand_hi`. Equal reference and candidate operands yield a result of 0.
- R2: Each pixel difference is taken as unsigned magnitude. Swapping the reference and candidate operands leaves the result unchanged.
- R3: `wb_sad` equals the sum of the eight absolute differences, zero-extended to 32 bits. The largest possible value is 2040, and bits 31 down to 12 are always 0.
- R4: When `issue_valid` is high at a rising edge, `wb_valid` is high after the third rising edge that follows, with the result of that operand set on `wb_sad`.
- R5: Operand sets issued on consecutive cycles produce results on consecutive cycles, in issue order, with no gap.
- R6: A synchronous active-low reset clears every valid flag in the pipeline. `wb_valid` is low while reset is held, and an operand set already inside the pipeline when reset arrives never appears at the output.
- R7: A cycle with `issue_valid` low produces no result. `wb_valid` is high only when an issue occurred three cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | Operand set present this cycle |
| ref_lo | input | 32 | Reference pixels 0 to 3 |
| ref_hi | input | 32 | Reference pixels 4 to 7 |
| cand_lo | input | 32 | Candidate pixels 0 to 3 |
| cand_hi | input | 32 | Candidate pixels 4 to 7 |
| wb_valid | output | 1 | Result present on `wb_sad` |
| wb_sad | output | 32 | Sum of absolute differences, zero-extended |

## Verification
The assertions watch every cycle for four things: the three-cycle latency from issue to result, the absence of a result without a matching issue, the zero upper bits and the 2040 ceiling of the sum, and the zero result for identical operands. Checking each sum against an independent model has to be done by the bench's scenarios. So do lane pairing, operand swap symmetry, back-to-back ordering, and a flush by reset of an operand set already in flight.

// File: rtl/sad_pkg.sv
// sad_pkg: width helpers shared by the stages of the SAD pipeline.
// Assumes unsigned pixels and that every sum is held at its full width.
package sad_pkg;
    localparam int DEF_PIX_W = 8;
    localparam int DEF_LANES = 4;

    // Partial sum width: pixel width, growth for the lane count, one guard bit.
    function automatic int psum_width(input int pix_w, input int lanes);
        return pix_w + $clog2(lanes) + 1;
    endfunction
endpackage

// File: rtl/sad_diff_stage.sv
// sad_diff_stage: stage 1. Registers |ref - cand| for every pixel lane.
// Assumes unsigned pixels packed in lane order. Only the valid flag is reset.
module sad_diff_stage #(
    parameter int PIX_W = 8,
    parameter int NPIX  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NPIX*PIX_W-1:0] ref_pix,
    input  logic [NPIX*PIX_W-1:0] cand_pix,
    output logic                  out_valid,
    output logic [NPIX*PIX_W-1:0] diff_q
);
    // Valid flag follows the issue and is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    for (genvar g = 0; g < NPIX; g++) begin : g_lane
        logic [PIX_W-1:0] a, b;
        assign a = ref_pix[g*PIX_W +: PIX_W];
        assign b = cand_pix[g*PIX_W +: PIX_W];
        // Magnitude of the lane difference, registered.
        always_ff @(posedge clk) begin
            diff_q[g*PIX_W +: PIX_W] <= (a >= b) ? (a - b) : (b - a);
        end
    end
endmodule

// File: rtl/sad_partial_stage.sv
// sad_partial_stage: stage 2. Adds the lane differences of each word pair
// into its own partial sum. Assumes PSUM_W can hold LANES full-scale values.
module sad_partial_stage #(
    parameter int PIX_W  = 8,
    parameter int LANES  = 4,
    parameter int GROUPS = 2,
    parameter int PSUM_W = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [GROUPS*LANES*PIX_W-1:0]  diff_in,
    output logic                           out_valid,
    output logic [GROUPS*PSUM_W-1:0]       psum_q
);
    // Valid flag follows stage 1 and is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        logic [PSUM_W-1:0] acc;
        // Sum of the four zero-extended differences of this word pair.
        always_comb begin
            acc = '0;
            for (int l = 0; l < LANES; l++) begin
                acc = acc + PSUM_W'(diff_in[(g*LANES + l)*PIX_W +: PIX_W]);
            end
        end
        // Register the partial sum.
        always_ff @(posedge clk) begin
            psum_q[g*PSUM_W +: PSUM_W] <= acc;
        end
    end
endmodule

// File: rtl/sad_final_stage.sv
// sad_final_stage: stage 3. Adds the partial sums and zero-extends the
// total to the writeback width. Assumes OUT_W >= SUM_W.
module sad_final_stage #(
    parameter int PSUM_W = 11,
    parameter int GROUPS = 2,
    parameter int SUM_W  = 12,
    parameter int OUT_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [GROUPS*PSUM_W-1:0]  psum_in,
    output logic                      out_valid,
    output logic [OUT_W-1:0]          sum_q
);
    logic [SUM_W-1:0] total;

    // Add the partial sums at full width.
    always_comb begin
        total = '0;
        for (int g = 0; g < GROUPS; g++) begin
            total = total + SUM_W'(psum_in[g*PSUM_W +: PSUM_W]);
        end
    end

    // Valid flag follows stage 2 and is cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Register the zero-extended total.
    always_ff @(posedge clk) begin
        sum_q <= OUT_W'(total);
    end
endmodule

// File: rtl/sad_pipe.sv
// sad_pipe: three-stage sum of absolute differences over two word pairs.
// Accepts one operand set per cycle and returns it three cycles later.
// Assumes unsigned pixels, little-endian within each word, no backpressure.
module sad_pipe #(
    parameter int PIX_W = sad_pkg::DEF_PIX_W,
    parameter int LANES = sad_pkg::DEF_LANES,
    parameter int OUT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_valid,
    input  logic [PIX_W*LANES-1:0] ref_lo,
    input  logic [PIX_W*LANES-1:0] ref_hi,
    input  logic [PIX_W*LANES-1:0] cand_lo,
    input  logic [PIX_W*LANES-1:0] cand_hi,
    output logic                   wb_valid,
    output logic [OUT_W-1:0]       wb_sad
);
    localparam int GROUPS = 2;
    localparam int WORD_W = PIX_W * LANES;
    localparam int NPIX   = GROUPS * LANES;
    localparam int PSUM_W = sad_pkg::psum_width(PIX_W, LANES);
    localparam int SUM_W  = PSUM_W + $clog2(GROUPS);

    logic [GROUPS*WORD_W-1:0] ref_all, cand_all;
    logic                     v1, v2;
    logic [NPIX*PIX_W-1:0]    diff;
    logic [GROUPS*PSUM_W-1:0] psum;

    assign ref_all  = {ref_hi, ref_lo};
    assign cand_all = {cand_hi, cand_lo};

    sad_diff_stage #(.PIX_W(PIX_W), .NPIX(NPIX)) u_diff (
        .clk(clk), .rst_n(rst_n), .in_valid(issue_valid),
        .ref_pix(ref_all), .cand_pix(cand_all),
        .out_valid(v1), .diff_q(diff)
    );

    sad_partial_stage #(.PIX_W(PIX_W), .LANES(LANES), .GROUPS(GROUPS),
                        .PSUM_W(PSUM_W)) u_part (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .diff_in(diff),
        .out_valid(v2), .psum_q(psum)
    );

    sad_final_stage #(.PSUM_W(PSUM_W), .GROUPS(GROUPS), .SUM_W(SUM_W),
                      .OUT_W(OUT_W)) u_final (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .psum_in(psum),
        .out_valid(wb_valid), .sum_q(wb_sad)
    );
endmodule

// File: rtl/sad_pipe_checker.sv
// sad_pipe_checker: port-level properties of sad_pipe, bound to every
// instance. Assumes the three-stage latency of the design.
module sad_pipe_checker #(
    parameter int PIX_W = 8,
    parameter int LANES = 4,
    parameter int OUT_W = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   issue_valid,
    input logic [PIX_W*LANES-1:0] ref_lo,
    input logic [PIX_W*LANES-1:0] ref_hi,
    input logic [PIX_W*LANES-1:0] cand_lo,
    input logic [PIX_W*LANES-1:0] cand_hi,
    input logic                   wb_valid,
    input logic [OUT_W-1:0]       wb_sad
);
    localparam int MAX_SUM = 2 * LANES * ((1 << PIX_W) - 1);

    logic [1:0] since_rst;
    logic       same_ops;

    assign same_ops = (ref_lo == cand_lo) && (ref_hi == cand_hi);

    // Saturating count of edges since reset, guarding $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ##3 wb_valid);

    a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && wb_valid) |-> $past(issue_valid, 3));

    a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_sad <= OUT_W'(MAX_SUM)));

    a_r1_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && wb_valid && $past(same_ops, 3)) |-> (wb_sad == '0));

    a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !wb_valid);
endmodule

bind sad_pipe sad_pipe_checker #(.PIX_W(PIX_W), .LANES(LANES), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
    .ref_lo(ref_lo), .ref_hi(ref_hi), .cand_lo(cand_lo), .cand_hi(cand_hi),
    .wb_valid(wb_valid), .wb_sad(wb_sad)
);

// File: tb/tb_sad_pipe.sv
// tb_sad_pipe: streams a vector table back to back, then runs directed
// tests for reset, lane pairing, symmetry, saturation and idle cycles.
module tb_sad_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    localparam logic [31:0] V_RLO [NVEC] = '{32'h0403_0201, 32'hFFFF_FFFF, 32'h1234_5678,
        32'h0000_00FF, 32'h8080_8080, 32'h0A14_1E28, 32'h0000_0000, 32'hDEAD_BEEF};
    localparam logic [31:0] V_RHI [NVEC] = '{32'h0807_0605, 32'hFFFF_FFFF, 32'h9ABC_DEF0,
        32'h0000_0000, 32'h7F7F_7F7F, 32'h3246_505A, 32'h0000_0001, 32'hCAFE_F00D};
    localparam logic [31:0] V_CLO [NVEC] = '{32'h0403_0201, 32'h0000_0000, 32'h8765_4321,
        32'hFF00_0000, 32'h7F7F_7F7F, 32'h2814_1E0A, 32'h0000_0000, 32'hDEAD_BEEF};
    localparam logic [31:0] V_CHI [NVEC] = '{32'h0807_0605, 32'h0000_0000, 32'h0FED_CBA9,
        32'h0000_0000, 32'h8080_8080, 32'h5A50_4632, 32'h0100_0000, 32'hCAFE_F00E};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [31:0] ref_lo = '0, ref_hi = '0, cand_lo = '0, cand_hi = '0;
    logic        wb_valid;
    logic [31:0] wb_sad;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sad_pipe dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .ref_lo(ref_lo), .ref_hi(ref_hi), .cand_lo(cand_lo), .cand_hi(cand_hi),
        .wb_valid(wb_valid), .wb_sad(wb_sad)
    );

    // Independent model: byte-wise unsigned magnitudes summed.
    function automatic logic [31:0] model(input logic [31:0] a0, a1, b0, b1);
        logic [31:0] s = 0;
        for (int i = 0; i < 4; i++) begin
            s += (a0[8*i +: 8] >= b0[8*i +: 8]) ? 32'(a0[8*i +: 8] - b0[8*i +: 8])
                                                : 32'(b0[8*i +: 8] - a0[8*i +: 8]);
            s += (a1[8*i +: 8] >= b1[8*i +: 8]) ? 32'(a1[8*i +: 8] - b1[8*i +: 8])
                                                : 32'(b1[8*i +: 8] - a1[8*i +: 8]);
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] a0, a1, b0, b1);
        issue_valid = v; ref_lo = a0; ref_hi = a1; cand_lo = b0; cand_hi = b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 50000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // Reset state (R6).
        repeat (3) @(negedge clk);
        check("R6 wb_valid in reset", 32'(wb_valid), 0);
        rst_n = 1'b1;

        // Stream the table back to back (R3, R4, R5, R1).
        for (int i = 0; i < NVEC + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                check("R5 wb_valid streamed", 32'(wb_valid), 1);
                check("R3 sum", wb_sad, model(V_RLO[i-3], V_RHI[i-3], V_CLO[i-3], V_CHI[i-3]));
            end
            if (i < NVEC) drive(1'b1, V_RLO[i], V_RHI[i], V_CLO[i], V_CHI[i]);
            else          drive(1'b0, '0, '0, '0, '0);
        end

        // Lane pairing: byte 0 against byte 3 must count both (R1).
        @(negedge clk); drive(1'b1, 32'h0000_00FF, 0, 32'hFF00_0000, 0);
        @(negedge clk); drive(1'b0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        check("R1 lane pairing", wb_sad, 510);

        // Swap symmetry (R2).
        @(negedge clk); drive(1'b1, 32'h1020_3040, 32'h0509_0D11, 32'h4030_2010, 32'h110D_0905);
        @(negedge clk); drive(1'b1, 32'h4030_2010, 32'h110D_0905, 32'h1020_3040, 32'h0509_0D11);
        @(negedge clk); drive(1'b0, 0, 0, 0, 0);
        @(negedge clk);
        check("R2 forward", wb_sad, model(32'h1020_3040, 32'h0509_0D11, 32'h4030_2010, 32'h110D_0905));
        @(negedge clk);
        check("R2 swapped", wb_sad, model(32'h1020_3040, 32'h0509_0D11, 32'h4030_2010, 32'h110D_0905));

        // Full scale: 2040 with upper bits zero (R3).
        @(negedge clk); drive(1'b1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        @(negedge clk); drive(1'b0, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        check("R3 full scale", wb_sad, 2040);

        // Idle cycles: only the issue cycle yields a result (R7, R4).
        repeat (3) @(negedge clk);
        drive(1'b1, 1, 2, 3, 4);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            drive(1'b0, 0, 0, 0, 0);
            check("R7 idle valid", 32'(wb_valid), (k == 3) ? 1 : 0);
        end

        // Reset while an operand set is in flight (R6).
        drive(1'b1, 32'hFF, 0, 0, 0);
        @(negedge clk); drive(1'b0, 0, 0, 0, 0); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R6 flushed", 32'(wb_valid), 0);
        end

        finish_run();
    end
endmodule